// File: doc/BRIEF.md
# Packed Vector Word Insert Unit

This execution unit writes one 16-bit word into a chosen lane of a packed vector and passes every other lane through unchanged. It has three operating modes. In the narrow legacy mode it merges into a 64-bit destination. In the wide legacy mode it merges into a 128-bit destination and leaves the bits above 127 alone. In the three-operand mode it takes a separate first source, replaces one of its words and clears everything from bit 128 upward. The lane number comes from the low bits of an 8-bit immediate.

An issue stage presents one operation per cycle on `op_valid`. The unit sees the decoded mode, the immediate, the encoded vector-length field, the operand-width bit, the current destination vector, the first-source vector and a 32-bit scalar. One cycle later it returns the registered result together with a one-cycle write strobe, or with an undefined-opcode fault in place of the strobe. The unit keeps no flags. It does not decode opcodes, read memory or hold the register file.

Top module: `simd_word_insert`

## Requirements
- R1: While `rst_n` is low, `res_o` is all zeros and `res_we` and `ud_fault` are both 0.
- R2: Only `scalar_in[15:0]` is inserted. Bits `[31:16]` of the scalar have no effect on the result.
- R3: In mode 0 (narrow, 64-bit) the lane is `imm[1:0]`, so word `k` occupies bits `[16k+15:16k]`. Bits `imm[7:2]` are ignored.
- R4: In mode 1 (wide, 128-bit) and in mode 2 (three-operand) the lane is `imm[2:0]`. Bits `imm[7:3]` are ignored.
- R5: In modes 0 and 1, every word of `dst_in` other than the selected one appears unchanged in `res_o`. In mode 0 this covers all bits above bit 63 as well.
- R6: In mode 1, bits `[MAXW-1:128]` of `res_o` equal those bits of `dst_in`.
- R7: In mode 2, `res_o[127:0]` is `src1_in` with the selected word replaced, and `dst_in` has no effect on the result.
- R8: In mode 2, bits `[MAXW-1:128]` of `res_o` are zero.
- R9: In mode 2 with a nonzero `vlen`, `ud_fault` is 1 and `res_we` is 0 in the result cycle, and `res_o` keeps its previous value.
- R10: `vlen` has no effect in modes 0 and 1. `wbit` has no effect in any mode.
- R11: An operation accepted while `op_valid` is 1 produces its result, with `res_we` or `ud_fault` high for exactly one cycle, on the next clock edge. When `op_valid` is 0, both strobes are 0 and `res_o` holds its value.
- R12: Mode code 3 is reserved. It raises `ud_fault` with `res_we` at 0 and leaves `res_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_mode | input | 2 | 0 narrow legacy, 1 wide legacy, 2 three-operand, 3 reserved |
| imm | input | 8 | Immediate byte carrying the lane number |
| vlen | input | 2 | Encoded vector-length field, legal only when zero in mode 2 |
| wbit | input | 1 | Operand-width prefix bit, ignored |
| dst_in | input | MAXW | Current destination vector |
| src1_in | input | 128 | First source vector for mode 2 |
| scalar_in | input | 32 | Scalar source, low word inserted |
| res_o | output | MAXW | Registered result vector |
| res_we | output | 1 | One-cycle write enable for `res_o` |
| ud_fault | output | 1 | One-cycle undefined-opcode fault |

## Verification
A behavioural reference model predicts the outputs every clock. Walking each lane in every mode with distinct patterns in destination, first source and scalar shows whether the selected lane is right and whether the neighbouring lanes pass through. Immediates with their high bits set, together with scalars that carry nonzero upper halves, separate a correct lane mask from a select field or a word slice that is too wide. Matching calls that differ only in `dst_in`, `vlen` or `wbit` show whether mode 2 ignores the destination, and whether the fault is tied to the three-operand mode alone.

// File: rtl/siw_pkg.sv
package siw_pkg;
   typedef enum logic [1:0] {
      SIW_NARROW64 = 2'd0,
      SIW_WIDE128  = 2'd1,
      SIW_THREEOP  = 2'd2,
      SIW_RSVD     = 2'd3
   } siw_mode_e;

   localparam int SIW_BASE_W   = 128;
   localparam int SIW_NARROW_W = 64;
endpackage

// File: rtl/siw_lane_dec.sv
module siw_lane_dec #(
   parameter int LANES  = 8,
   parameter int NLANES = 4,
   localparam int SELW  = $clog2(LANES),
   localparam int NSELW = $clog2(NLANES)
) (
   input  logic [SELW-1:0]  sel_in,
   input  logic             narrow,
   output logic [LANES-1:0] lane_oh
);
   generate
      if (NLANES > LANES || NLANES < 2) begin : g_bad
         $error("siw_lane_dec: NLANES must lie in 2..LANES");
      end
   endgenerate

   logic [SELW-1:0] eff_sel;

   always_comb begin
      eff_sel = sel_in;
      if (narrow) begin
         eff_sel = '0;
         eff_sel[NSELW-1:0] = sel_in[NSELW-1:0];
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_dec
         assign lane_oh[l] = (eff_sel == SELW'(l));
      end
   endgenerate
endmodule

// File: rtl/siw_lane_merge.sv
module siw_lane_merge #(
   parameter int WORDW = 16,
   parameter int LANES = 8,
   localparam int VW   = WORDW * LANES
) (
   input  logic [VW-1:0]    base_in,
   input  logic [WORDW-1:0] word_in,
   input  logic [LANES-1:0] lane_oh,
   output logic [VW-1:0]    merged
);
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign merged[l*WORDW +: WORDW] =
            lane_oh[l] ? word_in : base_in[l*WORDW +: WORDW];
      end
   endgenerate
endmodule

// File: rtl/simd_word_insert.sv
module simd_word_insert
   import siw_pkg::*;
#(
   parameter int MAXW   = 256,
   parameter int WORDW  = 16,
   parameter int SCALW  = 32,
   parameter int IMMW   = 8,
   parameter int VLW    = 2,
   localparam int BASEW  = SIW_BASE_W,
   localparam int LANES  = BASEW / WORDW,
   localparam int NLANES = SIW_NARROW_W / WORDW,
   localparam int SELW   = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [1:0]       op_mode,
   input  logic [IMMW-1:0]  imm,
   input  logic [VLW-1:0]   vlen,
   input  logic             wbit,
   input  logic [MAXW-1:0]  dst_in,
   input  logic [BASEW-1:0] src1_in,
   input  logic [SCALW-1:0] scalar_in,
   output logic [MAXW-1:0]  res_o,
   output logic             res_we,
   output logic             ud_fault
);
   generate
      if (MAXW < BASEW) begin : g_chk_maxw
         $error("simd_word_insert: MAXW must be at least 128");
      end
      if (SCALW < WORDW) begin : g_chk_scal
         $error("simd_word_insert: SCALW narrower than a word");
      end
      if (IMMW < SELW) begin : g_chk_imm
         $error("simd_word_insert: immediate too narrow for lane select");
      end
      if (BASEW % WORDW != 0) begin : g_chk_word
         $error("simd_word_insert: WORDW must divide 128");
      end
   endgenerate

   siw_mode_e mode;
   assign mode = siw_mode_e'(op_mode);

   logic is_tri, is_narrow, bad_op;
   assign is_tri    = (mode == SIW_THREEOP);
   assign is_narrow = (mode == SIW_NARROW64);
   assign bad_op    = (mode == SIW_RSVD) || (is_tri && (vlen != '0));

   logic unused_bits;
   assign unused_bits = ^{wbit, imm[IMMW-1:SELW], scalar_in[SCALW-1:WORDW]};

   logic [LANES-1:0] lane_oh;
   siw_lane_dec #(.LANES(LANES), .NLANES(NLANES)) u_dec (
      .sel_in  (imm[SELW-1:0]),
      .narrow  (is_narrow),
      .lane_oh (lane_oh)
   );

   logic [BASEW-1:0] base_vec, low_res;
   assign base_vec = is_tri ? src1_in : dst_in[BASEW-1:0];

   siw_lane_merge #(.WORDW(WORDW), .LANES(LANES)) u_merge (
      .base_in (base_vec),
      .word_in (scalar_in[WORDW-1:0]),
      .lane_oh (lane_oh),
      .merged  (low_res)
   );

   logic [MAXW-1:0] next_res;
   generate
      if (MAXW > BASEW) begin : g_upper
         assign next_res = {is_tri ? {(MAXW-BASEW){1'b0}} : dst_in[MAXW-1:BASEW], low_res};
      end else begin : g_exact
         assign next_res = low_res;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o    <= '0;
         res_we   <= 1'b0;
         ud_fault <= 1'b0;
      end else begin
         res_we   <= op_valid && !bad_op;
         ud_fault <= op_valid && bad_op;
         if (op_valid && !bad_op) res_o <= next_res;
      end
   end

   // R9
   fault_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ud_fault |-> !res_we);

   // R11
   we_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we || ud_fault) |-> $past(op_valid));

   // R12
   rsvd_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_mode == 2'd3) |=> (ud_fault && !res_we));

   // R9
   hold_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ud_fault |-> $stable(res_o));

   // R10
   legacy_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_mode[1] == 1'b0) |=> res_we);

   generate
      if (MAXW > BASEW) begin : g_upper_chk
         // R8
         tri_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op_mode == 2'd2 && vlen == '0) |=> (res_o[MAXW-1:BASEW] == '0));
         // R6
         wide_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op_mode == 2'd1) |=> (res_o[MAXW-1:BASEW] == $past(dst_in[MAXW-1:BASEW])));
      end
   endgenerate
endmodule

// File: tb/simd_word_insert_test.sv
module simd_word_insert_test;
   localparam int MAXW = 256;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             op_valid = 1'b0;
   logic [1:0]       op_mode = 2'd0;
   logic [7:0]       imm = 8'd0;
   logic [1:0]       vlen = 2'd0;
   logic             wbit = 1'b0;
   logic [MAXW-1:0]  dst_in = '0;
   logic [127:0]     src1_in = '0;
   logic [31:0]      scalar_in = '0;
   logic [MAXW-1:0]  res_o;
   logic             res_we, ud_fault;

   always #2 clk = ~clk;

   simd_word_insert #(.MAXW(MAXW)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
      .imm(imm), .vlen(vlen), .wbit(wbit), .dst_in(dst_in),
      .src1_in(src1_in), .scalar_in(scalar_in),
      .res_o(res_o), .res_we(res_we), .ud_fault(ud_fault)
   );

   int checks = 0;
   int fails  = 0;
   string cur_tag = "R1";
   bit done = 1'b0;

   logic [MAXW-1:0] exp_res = '0;
   logic exp_we = 1'b0, exp_fault = 1'b0;

   // Behavioural reference: integer lane index, loop over words.
   always @(posedge clk) begin
      logic [MAXW-1:0] n_res;
      logic n_we, n_fault;
      string tag;
      int sel;
      tag = cur_tag;
      n_res = exp_res; n_we = 0; n_fault = 0;
      if (!rst_n) begin
         n_res = '0;
      end else if (op_valid) begin
         if (op_mode == 2'd3 || (op_mode == 2'd2 && vlen != 0)) begin
            n_fault = 1;
         end else begin
            n_we = 1;
            sel = (op_mode == 2'd0) ? int'(imm % 4) : int'(imm % 8);
            if (op_mode == 2'd2) begin
               n_res = '0;
               n_res[127:0] = src1_in;
            end else begin
               n_res = dst_in;
            end
            for (int w = 0; w < 8; w++)
               if (w == sel) n_res[w*16 +: 16] = scalar_in[15:0];
         end
      end
      #1;
      checks++;
      if (res_o !== n_res || res_we !== n_we || ud_fault !== n_fault) begin
         fails++;
         $display("FAIL %s: res=%h we=%b fault=%b expected res=%h we=%b fault=%b",
                  tag, res_o, res_we, ud_fault, n_res, n_we, n_fault);
      end
      exp_res = n_res; exp_we = n_we; exp_fault = n_fault;
   end

   task automatic op(input logic [1:0] m, input logic [7:0] im, input logic [1:0] vl,
                     input logic w, input logic [MAXW-1:0] d, input logic [127:0] s1,
                     input logic [31:0] sc, input string tag);
      @(negedge clk);
      op_valid = 1; op_mode = m; imm = im; vlen = vl; wbit = w;
      dst_in = d; src1_in = s1; scalar_in = sc; cur_tag = tag;
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      op_valid = 0; cur_tag = tag;
      dst_in = ~dst_in; scalar_in = ~scalar_in;
   endtask

   function automatic logic [MAXW-1:0] pat(input int seed);
      logic [MAXW-1:0] v;
      for (int i = 0; i < MAXW/16; i++) v[i*16 +: 16] = 16'((seed * 16'h1111) ^ (i * 16'h0203) ^ 16'h8000);
      return v;
   endfunction

   initial begin
      cur_tag = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R3 narrow lanes, high imm bits set, R2 upper scalar bits nonzero
      for (int k = 0; k < 8; k++)
         op(2'd0, 8'(k) | 8'hF8, 2'd0, 1'b0, pat(k), pat(k+20)[127:0], 32'hDEAD0000 | 32'(k*16'h1357), "R3");
      // R4 wide lanes
      for (int k = 0; k < 8; k++)
         op(2'd1, 8'(k) | 8'hA8, 2'd0, 1'b0, pat(k+3), pat(k+9)[127:0], 32'hFFFF0000 | 32'(16'hA5A5 ^ k), "R4");
      // R5 / R6 legacy merge with full-ones and zeros destination
      op(2'd1, 8'd5, 2'd0, 1'b0, '1, '0, 32'h0000_1234, "R6");
      op(2'd0, 8'd2, 2'd0, 1'b0, '1, '0, 32'h0000_0000, "R5");
      // R2 scalar upper half differs only
      op(2'd1, 8'd3, 2'd0, 1'b0, pat(7), '0, 32'h0000_BEEF, "R2");
      op(2'd1, 8'd3, 2'd0, 1'b0, pat(7), '0, 32'hFFFF_BEEF, "R2");
      // R7 / R8 three-operand, destination varies
      for (int k = 0; k < 8; k++)
         op(2'd2, 8'(k) | 8'h70, 2'd0, 1'b0, pat(k+40), pat(k+50)[127:0], 32'h1234_0000 | 32'(k*16'h0F0F), "R7");
      op(2'd2, 8'd6, 2'd0, 1'b0, '1, pat(2)[127:0], 32'h0000_4321, "R8");
      op(2'd2, 8'd6, 2'd0, 1'b0, '0, pat(2)[127:0], 32'h0000_4321, "R8");
      // R9 fault with nonzero vlen, result held
      op(2'd2, 8'd1, 2'd1, 1'b0, pat(60), pat(61)[127:0], 32'h0000_7777, "R9");
      op(2'd2, 8'd1, 2'd3, 1'b1, pat(62), pat(63)[127:0], 32'h0000_8888, "R9");
      // R10 vlen and wbit ignored in legacy modes
      op(2'd0, 8'd1, 2'd3, 1'b1, pat(70), '0, 32'h0000_1111, "R10");
      op(2'd1, 8'd7, 2'd2, 1'b1, pat(71), '0, 32'h0000_2222, "R10");
      op(2'd2, 8'd0, 2'd0, 1'b1, pat(72), pat(73)[127:0], 32'h0000_3333, "R10");
      // R12 reserved mode
      op(2'd3, 8'd0, 2'd0, 1'b0, pat(80), pat(81)[127:0], 32'h0000_9999, "R12");
      // R11 idle cycles hold the result
      idle("R11"); idle("R11");
      op(2'd1, 8'd0, 2'd0, 1'b0, pat(90), '0, 32'h0000_CAFE, "R11");
      idle("R11");
      // mixed random traffic across modes
      for (int k = 0; k < 200; k++) begin
         if ($urandom % 4 == 0) idle("R11");
         else op(2'($urandom), 8'($urandom), 2'($urandom % 3 == 0 ? $urandom : 0), 1'($urandom),
                 {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, $urandom, "R4");
      end
      idle("R11"); idle("R11");
      // R1 reset again mid-run
      @(negedge clk); rst_n = 0; cur_tag = "R1";
      op_valid = 1; op_mode = 2'd1;
      repeat (2) @(negedge clk);
      op_valid = 0;
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule